// File: doc/BRIEF.md
# Predictive Drowsy Line Wakeup Controller

This block manages the low-leakage retention mode of the lines of an instruction cache. It sits in a stage placed between the branch predictor and the fetch stage. The branch predictor's next-fetch address serves directly as the wakeup prediction, and no separate table is kept. When an address is predicted in cycle t, the cache line it maps to is awake in cycle t+1, which is when the fetch stage reads it. Every other line stays at reduced supply voltage. A line in that state keeps its contents but cannot be read.

When a branch is mispredicted, the corrected target is presented on a redirect input. Its line is woken while recovery is still in progress, so a correctly timed refetch costs nothing extra. If a fetch reaches a line that is still drowsy, for example a redirected fetch with no recovery slack, the block raises a stall for that cycle and wakes the missing line so that the retried fetch succeeds. A fetch block that crosses a line boundary wakes both lines it touches.

Top module: `drowsy_wake_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bit of `wake_en` is 0 (every line drowsy). A valid fetch in that cycle raises `stall`.
- R2: The line index of an address is the field `addr[OFF_W +: IDX_W]`, where OFF_W = log2(LINE_BYTES) and IDX_W = log2(NUM_LINES). A predicted address with `pred_valid`=1 in cycle t sets `wake_en[index]` in cycle t+1.
- R3: A fetch block crosses a line boundary when `addr mod LINE_BYTES` + FETCH_BYTES > LINE_BYTES. In that case line (index+1) mod NUM_LINES is woken too, in the same cycle.
- R4: `wake_en` in cycle t+1 equals exactly the union of the lines requested in cycle t. A line woken earlier and not requested again returns to drowsy.
- R5: A redirect with `redir_valid`=1 in cycle t wakes the redirect target's line(s) in cycle t+1, together with the predicted line(s).
- R6: `stall` is 1 in the same cycle exactly when `fetch_valid`=1 and at least one line of the fetch block (R2/R3 mapping) has `wake_en` 0.
- R7: When `stall` is 1 in cycle t, the lines of the stalled fetch are awake in cycle t+1, so retrying the same address does not stall.
- R8: A fetch of the address predicted in the previous cycle never stalls. This holds for both single-line and boundary-crossing blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Branch predictor supplies a next-fetch address |
| pred_addr | input | ADDR_W | Predicted next fetch address |
| redir_valid | input | 1 | Misprediction redirect this cycle |
| redir_addr | input | ADDR_W | Corrected target address |
| fetch_valid | input | 1 | Fetch stage reads the cache this cycle |
| fetch_addr | input | ADDR_W | Address being fetched |
| wake_en | output | NUM_LINES | Per-line wake enable, 1 = full voltage |
| stall | output | 1 | Fetch must wait one cycle for a drowsy line |

## Verification
`stall` is combinational. Inputs are driven at the falling edge, and the bench checks `stall` 1 ns later, in the same cycle and against the wake state the bench's model holds for that cycle. `wake_en` changes one rising edge after its request. It is therefore checked 1 ns after that edge against the mask the model builds from the previous cycle's predicted, redirect and stalled-fetch addresses. The model then takes this mask as its state for the next cycle. Every address in two wraps of the cache is first swept as a prediction followed by its fetch. After that come long pseudo-random runs with mispredictions, both timely and with no slack.

// File: rtl/drowsy_wake_pkg.sv
package drowsy_wake_pkg;

    // request sources merged into the next wake mask
    typedef enum logic [1:0] {
        SRC_PRED  = 2'd0,
        SRC_REDIR = 2'd1,
        SRC_FETCH = 2'd2
    } wake_src_e;

    localparam int unsigned NUM_SRC = 3;

    // decoded placement of a fetch block in the line array
    typedef struct packed {
        logic        valid;
        logic        spans;
    } block_info_t;

    function automatic logic spans_boundary(input int unsigned offset,
                                            input int unsigned line_bytes,
                                            input int unsigned fetch_bytes);
        return (offset + fetch_bytes) > line_bytes;
    endfunction

endpackage

// File: rtl/dwc_line_decode.sv
module dwc_line_decode
    import drowsy_wake_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned LINE_BYTES  = 16,
    parameter int unsigned NUM_LINES   = 8,
    parameter int unsigned FETCH_BYTES = 8
) (
    input  logic                 en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LINES-1:0] mask
);
    localparam int unsigned OFF_W = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W = $clog2(NUM_LINES);

    logic [OFF_W-1:0] offset;
    logic [IDX_W-1:0] idx_lo;
    logic [IDX_W-1:0] idx_hi;
    block_info_t      info;

    always_comb begin
        offset      = addr[OFF_W-1:0];
        idx_lo      = addr[OFF_W +: IDX_W];
        idx_hi      = idx_lo + 1'b1;
        info.valid  = en;
        info.spans  = spans_boundary(int'(offset), LINE_BYTES, FETCH_BYTES);
        mask        = '0;
        if (info.valid) begin
            mask[idx_lo] = 1'b1;
            if (info.spans) begin
                mask[idx_hi] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dwc_line_state.sv
module dwc_line_state #(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] next_awake,
    output logic [NUM_LINES-1:0] awake
);
    always_ff @(posedge clk) begin
        if (rst) begin
            awake <= '0;
        end else begin
            awake <= next_awake;
        end
    end
endmodule

// File: rtl/dwc_stall_check.sv
module dwc_stall_check #(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 fetch_valid,
    input  logic [NUM_LINES-1:0] fetch_mask,
    input  logic [NUM_LINES-1:0] awake,
    output logic                 stall
);
    always_comb begin
        stall = fetch_valid && ((fetch_mask & ~awake) != '0);
    end
endmodule

// File: rtl/drowsy_wake_ctrl.sv
module drowsy_wake_ctrl
    import drowsy_wake_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned LINE_BYTES  = 16,
    parameter int unsigned NUM_LINES   = 8,
    parameter int unsigned FETCH_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pred_valid,
    input  logic [ADDR_W-1:0]    pred_addr,
    input  logic                 redir_valid,
    input  logic [ADDR_W-1:0]    redir_addr,
    input  logic                 fetch_valid,
    input  logic [ADDR_W-1:0]    fetch_addr,
    output logic [NUM_LINES-1:0] wake_en,
    output logic                 stall
);
    logic [NUM_SRC-1:0]                src_en;
    logic [NUM_SRC-1:0][ADDR_W-1:0]    src_addr;
    logic [NUM_SRC-1:0][NUM_LINES-1:0] src_mask;
    logic [NUM_LINES-1:0]              next_awake;

    always_comb begin
        src_en[SRC_PRED]    = pred_valid;
        src_addr[SRC_PRED]  = pred_addr;
        src_en[SRC_REDIR]   = redir_valid;
        src_addr[SRC_REDIR] = redir_addr;
        src_en[SRC_FETCH]   = fetch_valid;
        src_addr[SRC_FETCH] = fetch_addr;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_decode
        dwc_line_decode #(
            .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
            .NUM_LINES(NUM_LINES), .FETCH_BYTES(FETCH_BYTES)
        ) u_dec (
            .en(src_en[s]), .addr(src_addr[s]), .mask(src_mask[s])
        );
    end

    dwc_stall_check #(.NUM_LINES(NUM_LINES)) u_stall (
        .fetch_valid(fetch_valid),
        .fetch_mask (src_mask[SRC_FETCH]),
        .awake      (wake_en),
        .stall      (stall)
    );

    always_comb begin
        next_awake = src_mask[SRC_PRED] | src_mask[SRC_REDIR];
        if (stall) begin
            next_awake = next_awake | src_mask[SRC_FETCH];
        end
    end

    dwc_line_state #(.NUM_LINES(NUM_LINES)) u_state (
        .clk(clk), .rst(rst), .next_awake(next_awake), .awake(wake_en)
    );
endmodule

// File: rtl/drowsy_wake_ctrl_chk.sv
module drowsy_wake_ctrl_chk #(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned LINE_BYTES  = 16,
    parameter int unsigned NUM_LINES   = 8,
    parameter int unsigned FETCH_BYTES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pred_valid,
    input logic [ADDR_W-1:0]    pred_addr,
    input logic                 redir_valid,
    input logic [ADDR_W-1:0]    redir_addr,
    input logic                 fetch_valid,
    input logic [ADDR_W-1:0]    fetch_addr,
    input logic [NUM_LINES-1:0] wake_en,
    input logic                 stall
);
    function automatic logic [NUM_LINES-1:0] lines_of(input logic v, input logic [ADDR_W-1:0] a);
        int unsigned ln;
        logic [NUM_LINES-1:0] m;
        m  = '0;
        ln = (int'(a) / LINE_BYTES) % NUM_LINES;
        if (v) begin
            m[ln] = 1'b1;
            if ((int'(a) % LINE_BYTES) + FETCH_BYTES > LINE_BYTES) begin
                m[(ln + 1) % NUM_LINES] = 1'b1;
            end
        end
        return m;
    endfunction

    logic [NUM_LINES-1:0] want_p, want_r, want_f;
    always_comb begin
        want_p = lines_of(pred_valid, pred_addr);
        want_r = lines_of(redir_valid, redir_addr);
        want_f = lines_of(fetch_valid, fetch_addr);
    end

    // R1
    reset_drowsy_chk: assert property (@(posedge clk) rst |=> wake_en == '0);

    // R4
    only_requested_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wake_en & ~($past(want_p) | $past(want_r) | ($past(stall) ? $past(want_f) : '0))) == '0);

    // R2
    pred_wakes_chk: assert property (@(posedge clk) disable iff (rst)
        pred_valid |=> (wake_en & $past(want_p)) == $past(want_p));

    // R5
    redir_wakes_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (wake_en & $past(want_r)) == $past(want_r));

    // R6
    stall_needs_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> fetch_valid && ((want_f & ~wake_en) != '0));

    // R7
    stall_recovers_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> (wake_en & $past(want_f)) == $past(want_f));
endmodule

bind drowsy_wake_ctrl drowsy_wake_ctrl_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .NUM_LINES(NUM_LINES), .FETCH_BYTES(FETCH_BYTES)
) u_chk (
    .clk(clk), .rst(rst),
    .pred_valid(pred_valid), .pred_addr(pred_addr),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .wake_en(wake_en), .stall(stall)
);

// File: tb/drowsy_wake_ctrl_test.sv
`timescale 1ns/1ps
module drowsy_wake_ctrl_test;
    localparam int unsigned ADDR_W = 12, LB = 16, NL = 8, FB = 8;

    logic clk = 1'b0;
    logic rst;
    logic pv, rv, fv;
    logic [ADDR_W-1:0] pa, ra, fa;
    logic [NL-1:0] wake_en;
    logic stall;

    int n_chk = 0, n_bad = 0;
    logic [NL-1:0] model = '0;

    always #2.5 clk = ~clk;

    drowsy_wake_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .NUM_LINES(NL), .FETCH_BYTES(FB)) uut (
        .clk(clk), .rst(rst), .pred_valid(pv), .pred_addr(pa),
        .redir_valid(rv), .redir_addr(ra), .fetch_valid(fv), .fetch_addr(fa),
        .wake_en(wake_en), .stall(stall));

    function automatic logic [NL-1:0] lines(input logic v, input int unsigned a);
        logic [NL-1:0] m = '0;
        int unsigned ln = (a / LB) % NL;
        if (v) begin
            m[ln] = 1'b1;
            if ((a % LB) + FB > LB) m[(ln + 1) % NL] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [NL-1:0] got, input logic [NL-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // one cycle: drive at negedge, check stall, then wake mask after the edge
    task automatic cyc(input string rq, input logic p_v, input int unsigned p_a,
                       input logic r_v, input int unsigned r_a,
                       input logic f_v, input int unsigned f_a);
        logic [NL-1:0] fm, nxt;
        logic exp_st;
        @(negedge clk);
        pv = p_v; pa = ADDR_W'(p_a); rv = r_v; ra = ADDR_W'(r_a);
        fv = f_v; fa = ADDR_W'(f_a);
        fm = lines(f_v, f_a);
        exp_st = f_v && ((fm & ~model) != '0);
        #1;
        check({rq, "/R6 stall"}, NL'(stall), NL'(exp_st));
        nxt = lines(p_v, p_a) | lines(r_v, r_a) | (exp_st ? fm : '0);
        @(posedge clk); #1;
        check({rq, "/R4 wake"}, wake_en, nxt);
        model = nxt;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned prev;
        logic prev_v;
        rst = 1'b1; pv = 0; rv = 0; fv = 0; pa = '0; ra = '0; fa = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset wake", wake_en, '0);
        @(negedge clk); rst = 1'b0; fv = 1'b1; fa = '0; #1;
        // R1: fetch right after reset finds drowsy line
        check("R1 stall", NL'(stall), NL'(1));
        fv = 1'b0;
        model = '0;
        cyc("R1", 0, 0, 0, 0, 0, 0);

        // R2/R3/R8: sweep every address over two wraps, predict then fetch
        for (int a = 0; a < 2 * NL * LB; a++) begin
            cyc("R2", 1, a, 0, 0, 0, 0);
            cyc("R8", 0, 0, 0, 0, 1, a);
        end
        // R3: explicit crossing at the last line wraps to line 0
        cyc("R3", 1, (NL - 1) * LB + LB - 1, 0, 0, 0, 0);
        check("R3 wrap", wake_en, NL'(1) | (NL'(1) << (NL - 1)));
        // R4: previous lines return drowsy
        cyc("R4", 1, 2 * LB, 0, 0, 0, 0);
        check("R4 drop", wake_en, NL'(1) << 2);
        // R5: redirect plus prediction together
        cyc("R5", 1, 0, 1, 5 * LB, 0, 0);
        check("R5 both", wake_en, NL'(1) | (NL'(1) << 5));
        // R7: no-slack fetch stalls, retry succeeds
        cyc("R7", 0, 0, 0, 0, 1, 3 * LB + 12);
        cyc("R7", 0, 0, 0, 0, 1, 3 * LB + 12);

        // random runs with mispredictions
        prev = 0; prev_v = 0;
        for (int i = 0; i < 6000; i++) begin
            int unsigned p = $urandom % (4 * NL * LB);
            int unsigned t = $urandom % (4 * NL * LB);
            int unsigned k = $urandom % 10;
            if (k == 0)      cyc("R5", 1, p, 1, t, prev_v, t);   // no slack
            else if (k == 1) cyc("R5", 1, p, 1, t, 0, 0);        // timely redirect
            else if (k == 2) cyc("R6", 0, 0, 0, 0, 1, t);        // wild fetch
            else             cyc("R8", 1, p, 0, 0, prev_v, prev);
            prev = p; prev_v = (k != 2);
        end
        finish_run();
    end
endmodule